// File: doc/BRIEF.md
# Qualified Retired-Instruction Counter

This block holds a 64-bit running total of instructions that have left the pipeline. Software sees the total as two 32-bit control registers, one for the low half and one for the high half. Each half can be read, overwritten, bit-set or bit-cleared through a control-register access port.

The block has two qualification points. On the decode side it looks at the instruction about to move on. It raises a count qualifier only when that instruction is none of these:
- a breakpoint or environment call,
- an illegal instruction or an illegal control-register access,
- an instruction with a fetch fault,
- a modifying access (write, set or clear) to either counter half.

The pipeline carries this qualifier down to the writeback slot. On the writeback side the block combines the carried qualifier with slot-valid, completion and load/store error information. From these it produces a retire strobe, a speculative retire strobe and a compressed-instruction variant of the speculative strobe.

The counter advances on the retire strobe unless an inhibit input is high. A software modification in the same cycle always replaces the increment, so writing the counter is never followed by a stray step.

Top module: `retired_insn_counter`

## Requirements
- R1: When rst_ni is low the full 64-bit count is zero, so both cnt_lo_o and cnt_hi_o read 0.
- R2: count_id_o is 0 whenever ebrk_i or ecall_i is 1.
- R3: count_id_o is 0 whenever illegal_i, illegal_csr_i or fetch_err_i is 1.
- R4: count_id_o is 0 when csr_access_i is 1, csr_op_i is 1 (write), 2 (set) or 3 (clear), and csr_addr_i is 12'hB02 (low half) or 12'hB82 (high half). A read (csr_op_i = 0), another address, or csr_access_i = 0 leaves count_id_o at 1 when no other flag is set.
- R5: retire_o is wb_done_i and wb_count_i with no load/store error. Each cycle with retire_o high, inhibit_i low and no software modification adds exactly one to the count.
- R6: When lsu_resp_valid_i and lsu_resp_err_i are both 1, retire_o is 0 and the count does not advance. A valid response without error does not block counting.
- R7: spec_retire_o is 1 only when wb_count_i and wb_valid_i are both 1.
- R8: spec_retire_c_o equals spec_retire_o ANDed with wb_compressed_i.
- R9: A modification addressed to one half changes only that half, which is bits 31:0 for the low half and bits 63:32 for the high half. Write (1) loads csr_wdata_i, set (2) ORs it in, and clear (3) ANDs in its inverse. cnt_lo_o and cnt_hi_o show the registered halves.
- R10: When a software modification and a retire fall in the same cycle, the modification result is stored and no increment is applied.
- R11: An increment that carries out of the low half adds one to the high half in the same cycle.
- R12: While inhibit_i is 1 retires do not advance the count, but software modifications still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ebrk_i | input | 1 | Decode: instruction is a breakpoint |
| ecall_i | input | 1 | Decode: instruction is an environment call |
| illegal_i | input | 1 | Decode: illegal instruction |
| illegal_csr_i | input | 1 | Decode: illegal control-register access |
| fetch_err_i | input | 1 | Decode: instruction had a fetch fault |
| csr_access_i | input | 1 | Control-register access valid |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_addr_i | input | 12 | Control-register address |
| csr_wdata_i | input | 32 | Operand for write, set or clear |
| count_id_o | output | 1 | Decode-side count qualifier |
| wb_valid_i | input | 1 | Writeback slot holds a valid instruction |
| wb_count_i | input | 1 | Qualifier carried to the writeback slot |
| wb_compressed_i | input | 1 | Writeback instruction is compressed |
| wb_done_i | input | 1 | Writeback instruction completes this cycle |
| lsu_resp_valid_i | input | 1 | Load/store response valid |
| lsu_resp_err_i | input | 1 | Load/store response carries an error |
| inhibit_i | input | 1 | Freeze increments |
| retire_o | output | 1 | Qualified retire strobe |
| spec_retire_o | output | 1 | Speculative retire strobe |
| spec_retire_c_o | output | 1 | Speculative compressed retire strobe |
| cnt_lo_o | output | 32 | Count bits 31:0 |
| cnt_hi_o | output | 32 | Count bits 63:32 |

## Verification
The first set of checks walks the decode qualifier through every suppressing flag, and through counter-half accesses that should and should not suppress it. A decode that ignored the operation or the address would either count its own writes or stop counting plain reads.

The bench then loads the low half with all ones and retires one instruction. A broken carry would wrap the low half to zero and leave the high half unchanged.

Two more checks pair a write with a retire in the same cycle, and an inhibited retire with a write. A wrong priority shows up as an extra step after the written value, and a bad inhibit either counts anyway or blocks the write.

A load/store error on an otherwise counted retire and a speculative strobe with an empty writeback slot each catch a strobe that ignores its gating term.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    CSR_RD  = 2'd0,
    CSR_WR  = 2'd1,
    CSR_SET = 2'd2,
    CSR_CLR = 2'd3
  } csr_op_e;
endpackage

// File: rtl/rtc_csr_decode.sv
module rtc_csr_decode import rtc_pkg::*; #(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] LO_ADDR = 12'hB02,
  parameter logic [11:0] HI_ADDR = 12'hB82
) (
  input  logic              csr_access_i,
  input  csr_op_e           csr_op_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  output logic [1:0]        sw_we_o
);
  localparam logic [ADDR_W-1:0] ADDR_TAB [2] = '{LO_ADDR[ADDR_W-1:0], HI_ADDR[ADDR_W-1:0]};

  logic modify;
  assign modify = csr_access_i & (csr_op_i != CSR_RD);

  for (genvar h = 0; h < 2; h++) begin : g_sel
    assign sw_we_o[h] = modify & (csr_addr_i == ADDR_TAB[h]);
  end
endmodule

// File: rtl/rtc_qualify.sv
module rtc_qualify (
  input  logic       ebrk_i,
  input  logic       ecall_i,
  input  logic       illegal_i,
  input  logic       illegal_csr_i,
  input  logic       fetch_err_i,
  input  logic [1:0] sw_we_i,
  input  logic       wb_valid_i,
  input  logic       wb_count_i,
  input  logic       wb_compressed_i,
  input  logic       wb_done_i,
  input  logic       lsu_resp_valid_i,
  input  logic       lsu_resp_err_i,
  output logic       count_id_o,
  output logic       retire_o,
  output logic       spec_retire_o,
  output logic       spec_retire_c_o
);
  logic trap_like;
  assign trap_like  = ebrk_i | ecall_i | illegal_i | illegal_csr_i | fetch_err_i;
  // self-modification of the counter must not count itself
  assign count_id_o = ~trap_like & ~(|sw_we_i);

  assign retire_o        = wb_done_i & wb_count_i & ~(lsu_resp_valid_i & lsu_resp_err_i);
  assign spec_retire_o   = wb_count_i & wb_valid_i;
  assign spec_retire_c_o = spec_retire_o & wb_compressed_i;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter import rtc_pkg::*; #(
  parameter int CNT_W  = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [1:0]        sw_we_i,
  input  csr_op_e           csr_op_i,
  input  logic [HALF_W-1:0] csr_wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic [1:0][HALF_W-1:0]      half_mod;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] cur;
    assign cur = cnt_q[h*HALF_W +: HALF_W];
    always_comb begin
      case (csr_op_i)
        CSR_SET: half_mod[h] = cur | csr_wdata_i;
        CSR_CLR: half_mod[h] = cur & ~csr_wdata_i;
        default: half_mod[h] = csr_wdata_i;
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (|sw_we_i) begin
      // software wins over a same-cycle increment
      for (int h = 0; h < 2; h++) begin
        if (sw_we_i[h]) cnt_d[h*HALF_W +: HALF_W] = half_mod[h];
      end
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/retired_insn_counter.sv
module retired_insn_counter import rtc_pkg::*; #(
  parameter int          CNT_W   = 64,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] LO_ADDR = 12'hB02,
  parameter logic [11:0] HI_ADDR = 12'hB82,
  localparam int         HALF_W  = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ebrk_i,
  input  logic              ecall_i,
  input  logic              illegal_i,
  input  logic              illegal_csr_i,
  input  logic              fetch_err_i,
  input  logic              csr_access_i,
  input  logic [1:0]        csr_op_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [HALF_W-1:0] csr_wdata_i,
  output logic              count_id_o,
  input  logic              wb_valid_i,
  input  logic              wb_count_i,
  input  logic              wb_compressed_i,
  input  logic              wb_done_i,
  input  logic              lsu_resp_valid_i,
  input  logic              lsu_resp_err_i,
  input  logic              inhibit_i,
  output logic              retire_o,
  output logic              spec_retire_o,
  output logic              spec_retire_c_o,
  output logic [HALF_W-1:0] cnt_lo_o,
  output logic [HALF_W-1:0] cnt_hi_o
);
  csr_op_e          op;
  logic [1:0]       sw_we;
  logic [CNT_W-1:0] cnt;

  assign op = csr_op_e'(csr_op_i);

  rtc_csr_decode #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_decode (
    .csr_access_i(csr_access_i),
    .csr_op_i    (op),
    .csr_addr_i  (csr_addr_i),
    .sw_we_o     (sw_we)
  );

  rtc_qualify u_qualify (
    .ebrk_i          (ebrk_i),
    .ecall_i         (ecall_i),
    .illegal_i       (illegal_i),
    .illegal_csr_i   (illegal_csr_i),
    .fetch_err_i     (fetch_err_i),
    .sw_we_i         (sw_we),
    .wb_valid_i      (wb_valid_i),
    .wb_count_i      (wb_count_i),
    .wb_compressed_i (wb_compressed_i),
    .wb_done_i       (wb_done_i),
    .lsu_resp_valid_i(lsu_resp_valid_i),
    .lsu_resp_err_i  (lsu_resp_err_i),
    .count_id_o      (count_id_o),
    .retire_o        (retire_o),
    .spec_retire_o   (spec_retire_o),
    .spec_retire_c_o (spec_retire_c_o)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (retire_o & ~inhibit_i),
    .sw_we_i    (sw_we),
    .csr_op_i   (op),
    .csr_wdata_i(csr_wdata_i),
    .cnt_o      (cnt)
  );

  assign cnt_lo_o = cnt[HALF_W-1:0];
  assign cnt_hi_o = cnt[CNT_W-1:HALF_W];
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int HALF_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ebrk_i,
  input logic              ecall_i,
  input logic              illegal_i,
  input logic              illegal_csr_i,
  input logic              fetch_err_i,
  input logic [1:0]        csr_op_i,
  input logic [HALF_W-1:0] csr_wdata_i,
  input logic [1:0]        sw_we_i,
  input logic              count_id_o,
  input logic              wb_valid_i,
  input logic              wb_done_i,
  input logic              wb_count_i,
  input logic              lsu_resp_valid_i,
  input logic              lsu_resp_err_i,
  input logic              inhibit_i,
  input logic              retire_o,
  input logic              spec_retire_o,
  input logic              spec_retire_c_o,
  input logic [HALF_W-1:0] cnt_lo_o,
  input logic [HALF_W-1:0] cnt_hi_o
);
  logic [2*HALF_W-1:0] cnt;
  assign cnt = {cnt_hi_o, cnt_lo_o};

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_zero_r1: assert (cnt == '0);
  end

  p_brk_ecall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ebrk_i | ecall_i) |-> !count_id_o);

  p_illegal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_i | illegal_csr_i | fetch_err_i) |-> !count_id_o);

  p_self_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sw_we_i) |-> !count_id_o);

  p_step_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_done_i & wb_count_i & !lsu_resp_valid_i & !inhibit_i & !(|sw_we_i))
      |=> cnt == $past(cnt) + 1'b1);

  p_lsu_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsu_resp_valid_i & lsu_resp_err_i & !(|sw_we_i)) |-> !retire_o ##1 $stable(cnt));

  p_spec_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |-> !spec_retire_o);

  p_spec_c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_retire_c_o |-> spec_retire_o);

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i == 2'b01 && csr_op_i == 2'd1) |=> cnt_lo_o == $past(csr_wdata_i));

  p_inhibit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i & !(|sw_we_i)) |=> $stable(cnt));
endmodule

bind retired_insn_counter rtc_checker #(.HALF_W(HALF_W)) u_rtc_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ebrk_i          (ebrk_i),
  .ecall_i         (ecall_i),
  .illegal_i       (illegal_i),
  .illegal_csr_i   (illegal_csr_i),
  .fetch_err_i     (fetch_err_i),
  .csr_op_i        (csr_op_i),
  .csr_wdata_i     (csr_wdata_i),
  .sw_we_i         (sw_we),
  .count_id_o      (count_id_o),
  .wb_valid_i      (wb_valid_i),
  .wb_done_i       (wb_done_i),
  .wb_count_i      (wb_count_i),
  .lsu_resp_valid_i(lsu_resp_valid_i),
  .lsu_resp_err_i  (lsu_resp_err_i),
  .inhibit_i       (inhibit_i),
  .retire_o        (retire_o),
  .spec_retire_o   (spec_retire_o),
  .spec_retire_c_o (spec_retire_c_o),
  .cnt_lo_o        (cnt_lo_o),
  .cnt_hi_o        (cnt_hi_o)
);

// File: tb/retired_insn_counter_tb_top.sv
`timescale 1ns/1ps
module retired_insn_counter_tb_top;
  localparam logic [11:0] A_LO = 12'hB02;
  localparam logic [11:0] A_HI = 12'hB82;
  localparam logic [11:0] A_OT = 12'h300;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ebrk, ecall, ill, ill_csr, ferr, acc;
  logic [1:0]  op;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        count_id, wb_valid, wb_count, wb_comp, wb_done, lsu_v, lsu_e, inhibit;
  logic        retire, spec, spec_c;
  logic [31:0] lo, hi;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  retired_insn_counter dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .ebrk_i(ebrk), .ecall_i(ecall), .illegal_i(ill), .illegal_csr_i(ill_csr),
    .fetch_err_i(ferr), .csr_access_i(acc), .csr_op_i(op), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .count_id_o(count_id),
    .wb_valid_i(wb_valid), .wb_count_i(wb_count), .wb_compressed_i(wb_comp),
    .wb_done_i(wb_done), .lsu_resp_valid_i(lsu_v), .lsu_resp_err_i(lsu_e),
    .inhibit_i(inhibit), .retire_o(retire), .spec_retire_o(spec),
    .spec_retire_c_o(spec_c), .cnt_lo_o(lo), .cnt_hi_o(hi)
  );

  // {exp, ebrk, ecall, ill, ill_csr, ferr, acc, op[1:0], addr_sel[1:0]}; sel 0 lo, 1 hi, 2 other
  localparam logic [10:0] QVEC [13] = '{
    11'b1_00000_0_00_00,
    11'b0_10000_0_00_00,
    11'b0_01000_0_00_00,
    11'b0_00100_0_00_00,
    11'b0_00010_0_00_00,
    11'b0_00001_0_00_00,
    11'b1_00000_1_00_00,
    11'b0_00000_1_01_00,
    11'b0_00000_1_10_01,
    11'b0_00000_1_11_00,
    11'b1_00000_1_01_10,
    11'b1_00000_0_01_00,
    11'b1_00000_1_00_01
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic csr(logic [1:0] o, logic [11:0] a, logic [31:0] d);
    acc = 1'b1; op = o; addr = a; wdata = d;
    tick();
    acc = 1'b0; op = 2'd0; wdata = '0;
  endtask

  initial begin
    {ebrk, ecall, ill, ill_csr, ferr, acc} = '0;
    op = '0; addr = A_OT; wdata = '0;
    {wb_valid, wb_count, wb_comp, wb_done, lsu_v, lsu_e, inhibit} = '0;
    repeat (2) tick();
    chk("R1 reset count", {hi, lo}, 64'd0);
    rst_ni = 1'b1;
    tick();

    // qualifier table (writes carry zero data to an all-zero counter)
    for (int i = 0; i < 13; i++) begin
      {ebrk, ecall, ill, ill_csr, ferr, acc, op} = QVEC[i][9:2];
      addr = (QVEC[i][1:0] == 2'd0) ? A_LO : (QVEC[i][1:0] == 2'd1) ? A_HI : A_OT;
      #1;
      chk($sformatf("R2 R3 R4 qualifier vec %0d", i), {63'd0, count_id}, {63'd0, QVEC[i][10]});
    end
    {ebrk, ecall, ill, ill_csr, ferr, acc} = '0;
    op = '0; addr = A_OT;
    tick();
    chk("R4 zero-data accesses leave count", {hi, lo}, 64'd0);

    wb_done = 1'b1; wb_count = 1'b1;
    repeat (4) tick();
    chk("R5 four retires", {hi, lo}, 64'd4);
    wb_count = 1'b0;
    tick();
    chk("R5 unqualified retire", {hi, lo}, 64'd4);
    wb_count = 1'b1; lsu_v = 1'b1; lsu_e = 1'b1;
    #1 chk("R6 retire strobe on lsu error", {63'd0, retire}, 64'd0);
    tick();
    chk("R6 lsu error blocks count", {hi, lo}, 64'd4);
    lsu_e = 1'b0;
    tick();
    chk("R6 lsu ok still counts", {hi, lo}, 64'd5);
    {wb_done, wb_count, lsu_v} = '0;

    csr(2'd1, A_LO, 32'hFFFF_FFFF);
    chk("R9 write low half", {hi, lo}, 64'h0000_0000_FFFF_FFFF);
    wb_done = 1'b1; wb_count = 1'b1;
    tick();
    {wb_done, wb_count} = '0;
    chk("R11 carry into high", {hi, lo}, 64'h0000_0001_0000_0000);

    csr(2'd2, A_HI, 32'h0000_00F0);
    chk("R9 set high half", {hi, lo}, 64'h0000_00F1_0000_0000);
    csr(2'd3, A_HI, 32'h0000_0001);
    chk("R9 clear high half", {hi, lo}, 64'h0000_00F0_0000_0000);

    wb_done = 1'b1; wb_count = 1'b1;
    csr(2'd1, A_LO, 32'd5);
    chk("R10 write beats retire", {hi, lo}, 64'h0000_00F0_0000_0005);

    inhibit = 1'b1;
    tick();
    chk("R12 inhibit freezes", {hi, lo}, 64'h0000_00F0_0000_0005);
    csr(2'd1, A_LO, 32'd9);
    chk("R12 write under inhibit", {hi, lo}, 64'h0000_00F0_0000_0009);
    inhibit = 1'b0;

    csr(2'd0, A_LO, 32'd0);
    chk("R4 read access does not block count", {hi, lo}, 64'h0000_00F0_0000_000A);
    {wb_done, wb_count} = '0;

    wb_valid = 1'b1; wb_count = 1'b1; wb_comp = 1'b0;
    #1;
    chk("R7 spec with valid slot", {62'd0, spec, spec_c}, 64'd2);
    wb_comp = 1'b1;
    #1;
    chk("R8 spec compressed", {62'd0, spec, spec_c}, 64'd3);
    wb_valid = 1'b0;
    #1;
    chk("R7 R8 spec with empty slot", {62'd0, spec, spec_c}, 64'd0);
    wb_count = 1'b0; wb_comp = 1'b0;

    rst_ni = 1'b0;
    #1;
    chk("R1 asynchronous reset", {hi, lo}, 64'd0);
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule